// File: doc/BRIEF.md
# I2C Slave Clock-Stretch Controller

This block decides when an I2C slave pulls SCL low so that the bus master waits while the host services the slave's data buffers. After each acknowledge slot, a strobe marks the falling edge of the ninth bit clock. The controller then decides whether the transfer must pause. In transmit direction it pauses whenever the transmit buffer is empty, whatever the configuration. In receive direction it pauses only when the stretch-enable configuration bit is set.

While paused, a clock-release bit reads 0 and the SCL pull-low enable is asserted. The host ends the pause by writing 1 to the release bit. When stretch-enable is set, the host may also write 0 to stretch the clock on its own. When stretch-enable is clear, such a write is dropped. A STOP condition or a disabled module always frees SCL. Each automatic pause starts with a one-cycle service-request pulse to the host.

The controller is built around four states:

- `ST_FREE`: SCL is released.
- `ST_TX_WAIT`: an automatic stretch in transmit direction.
- `ST_RX_WAIT`: an automatic stretch in receive direction.
- `ST_SW_HOLD`: a stretch requested by the host.

Transitions out of `ST_FREE`:

- **tx_trigger** moves to `ST_TX_WAIT`.
- **rx_trigger** moves to `ST_RX_WAIT`.
- **host_clear** moves to `ST_SW_HOLD`; from either wait state it also moves to `ST_SW_HOLD`.

Transitions back to `ST_FREE`:

- **host_release** returns from any hold state.
- **force_free** returns from any state on a STOP or when the module is disabled.

Top module: `i2c_stretch_ctrl`

## Requirements
- R1: After reset, rel_bit is 1, scl_hold is 0 and svc_irq is 0.
- R2: With SCL free, a ninth_fall strobe while dir_tx=1 and tx_full=0 makes rel_bit 0 and scl_hold 1 on the following clock.
- R3: A ninth_fall strobe while dir_tx=1 and tx_full=1 leaves SCL free.
- R4: The transmit stretch of R2 occurs for both values of stretch_en.
- R5: With dir_tx=0, a ninth_fall strobe holds SCL on the following clock if stretch_en=1, and leaves SCL free if stretch_en=0.
- R6: A host write (host_wr=1) with host_wdata=1 sets rel_bit to 1 and frees SCL on the following clock, from any hold.
- R7: A host write with host_wdata=0 clears rel_bit and holds SCL on the following clock when stretch_en=1. When stretch_en=0 the write is ignored and rel_bit is unchanged.
- R8: svc_irq is high for exactly the one cycle in which an automatic stretch (R2 or R5) first appears on scl_hold. It does not pulse for a host-requested stretch, or for a strobe while SCL is already held.
- R9: stop_det=1 or enable=0 forces rel_bit to 1 and scl_hold to 0 on the following clock, overriding every other input.
- R10: When a stretch trigger and a host write arrive in the same cycle with SCL free, the trigger wins.
- R11: scl_hold is always the inverse of rel_bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Module enable; 0 forces SCL free |
| dir_tx | input | 1 | 1 = slave transmits, 0 = slave receives |
| ninth_fall | input | 1 | One-cycle strobe at the ninth SCL falling edge |
| tx_full | input | 1 | Transmit buffer holds a byte |
| stretch_en | input | 1 | Enables receive stretching and host clearing |
| stop_det | input | 1 | One-cycle strobe on a STOP condition |
| host_wr | input | 1 | Host write strobe to the release bit |
| host_wdata | input | 1 | Value written to the release bit |
| scl_hold | output | 1 | Pull SCL low when 1 |
| rel_bit | output | 1 | Clock-release status, 1 = released |
| svc_irq | output | 1 | One-cycle service request at an automatic stretch |

## Verification
The bench targets several corner cases:

- **Transmit with a full buffer.** A design that ignored tx_full would hold SCL here.
- **Transmit with stretch_en=0.** A design that gated transmit stretching with the enable would run the master over an empty buffer.
- **Host clear with stretch_en=0.** If the write leaked through, SCL would lock low.
- **Trigger and host write in the same cycle.** Giving the host priority would lose the pause.
- **STOP during a hold.** If a STOP did not override the hold, the bus would stay stalled.
- **Repeated strobes during a hold, and host-requested holds.** The bench checks that svc_irq does not pulse again; a level-style interrupt would.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;
    typedef enum logic [1:0] {
        ST_FREE    = 2'd0,
        ST_TX_WAIT = 2'd1,
        ST_RX_WAIT = 2'd2,
        ST_SW_HOLD = 2'd3
    } stretch_state_t;
endpackage

// File: rtl/i2c_stretch_trig.sv
module i2c_stretch_trig (
    input  logic dir_tx,
    input  logic ninth_fall,
    input  logic tx_full,
    input  logic stretch_en,
    output logic tx_trig,
    output logic rx_trig
);
    // transmit pause is mandatory when the buffer is empty
    always_comb begin
        tx_trig = ninth_fall && dir_tx && !tx_full;
        rx_trig = ninth_fall && !dir_tx && stretch_en;
    end
endmodule

// File: rtl/i2c_stretch_hostreq.sv
module i2c_stretch_hostreq (
    input  logic host_wr,
    input  logic host_wdata,
    input  logic stretch_en,
    output logic host_release,
    output logic host_clear
);
    // a clearing write only counts when software stretching is enabled
    always_comb begin
        host_release = host_wr && host_wdata;
        host_clear   = host_wr && !host_wdata && stretch_en;
    end
endmodule

// File: rtl/i2c_stretch_ctrl.sv
module i2c_stretch_ctrl
    import i2c_stretch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dir_tx,
    input  logic ninth_fall,
    input  logic tx_full,
    input  logic stretch_en,
    input  logic stop_det,
    input  logic host_wr,
    input  logic host_wdata,
    output logic scl_hold,
    output logic rel_bit,
    output logic svc_irq
);
    stretch_state_t state_q, state_d;
    logic           irq_d, irq_q;
    logic           tx_trig, rx_trig;
    logic           host_release, host_clear;
    logic           force_free;

    i2c_stretch_trig u_trig (
        .dir_tx     (dir_tx),
        .ninth_fall (ninth_fall),
        .tx_full    (tx_full),
        .stretch_en (stretch_en),
        .tx_trig    (tx_trig),
        .rx_trig    (rx_trig)
    );

    i2c_stretch_hostreq u_host (
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .stretch_en   (stretch_en),
        .host_release (host_release),
        .host_clear   (host_clear)
    );

    assign force_free = !enable || stop_det;

    // next-state decision
    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        if (force_free) begin
            state_d = ST_FREE;
        end else begin
            unique case (state_q)
                ST_FREE: begin
                    if (tx_trig) begin
                        state_d = ST_TX_WAIT;
                        irq_d   = 1'b1;
                    end else if (rx_trig) begin
                        state_d = ST_RX_WAIT;
                        irq_d   = 1'b1;
                    end else if (host_clear) begin
                        state_d = ST_SW_HOLD;
                    end
                end
                ST_TX_WAIT, ST_RX_WAIT: begin
                    if (host_release)    state_d = ST_FREE;
                    else if (host_clear) state_d = ST_SW_HOLD;
                end
                ST_SW_HOLD: begin
                    if (host_release) state_d = ST_FREE;
                end
                default: state_d = ST_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= irq_d;
        end
    end

    // outputs
    always_comb begin
        rel_bit  = (state_q == ST_FREE);
        scl_hold = (state_q != ST_FREE);
        svc_irq  = irq_q;
    end

    a_r2_tx_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !stop_det && rel_bit && ninth_fall && dir_tx && !tx_full)
        |=> (scl_hold && !rel_bit));

    a_r3_tx_full_free: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_bit && ninth_fall && dir_tx && tx_full && !host_wr)
        |=> rel_bit);

    a_r5_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_bit && ninth_fall && !dir_tx && !stretch_en)
        |=> rel_bit);

    a_r7_ignore_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !stop_det && host_wr && !host_wdata && !stretch_en && !ninth_fall)
        |=> $stable(rel_bit));

    a_r8_irq_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |-> $fell(rel_bit));

    a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        svc_irq |=> !svc_irq);

    a_r9_force_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || stop_det) |=> (rel_bit && !scl_hold));

    always_comb begin
        if (rst_n) begin
            a_r11_inverse: assert (scl_hold == !rel_bit);
        end
    end
endmodule

// File: tb/sim_i2c_stretch_ctrl.sv
module sim_i2c_stretch_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, dir_tx = 1'b0, ninth_fall = 1'b0, tx_full = 1'b0;
    logic stretch_en = 1'b0, stop_det = 1'b0, host_wr = 1'b0, host_wdata = 1'b0;
    logic scl_hold, rel_bit, svc_irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic m_rel = 1'b1;
    logic m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_stretch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .dir_tx(dir_tx),
        .ninth_fall(ninth_fall), .tx_full(tx_full), .stretch_en(stretch_en),
        .stop_det(stop_det), .host_wr(host_wr), .host_wdata(host_wdata),
        .scl_hold(scl_hold), .rel_bit(rel_bit), .svc_irq(svc_irq)
    );

    function automatic logic [1:0] model_next(logic rel, logic en, logic stp,
            logic tx, logic nf, logic full, logic sen, logic wr, logic wd);
        // returns {rel, irq}
        if (!en || stp) return 2'b10;
        if (rel && nf && ((tx && !full) || (!tx && sen))) return 2'b01;
        if (wr && wd) return 2'b10;
        if (wr && !wd && sen) return {1'b0, 1'b0};
        return {rel, 1'b0};
    endfunction

    task automatic check(string tag);
        n_cmp++;
        if (rel_bit !== m_rel || scl_hold !== !m_rel || svc_irq !== m_irq) begin
            n_bad++;
            $display("FAIL %s: rel/hold/irq actual %b%b%b expected %b%b%b",
                     tag, rel_bit, scl_hold, svc_irq, m_rel, !m_rel, m_irq);
        end
    endtask

    // drive at negedge, model at posedge, compare at next negedge
    task automatic step(logic en, logic stp, logic tx, logic nf, logic full,
                        logic sen, logic wr, logic wd, string tag);
        logic [1:0] nx;
        enable = en; stop_det = stp; dir_tx = tx; ninth_fall = nf;
        tx_full = full; stretch_en = sen; host_wr = wr; host_wdata = wd;
        @(posedge clk);
        nx = model_next(m_rel, en, stp, tx, nf, full, sen, wr, wd);
        m_rel = nx[1];
        m_irq = nx[0];
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        step(1'b1, 1'b0, dir_tx, 1'b0, tx_full, stretch_en, 1'b0, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'd7341));
        repeat (3) @(negedge clk);
        check("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R2 and R4: transmit stretch with stretch_en 0 and 1
        step(1, 0, 1, 1, 0, 0, 0, 0, "R2 R4 tx stretch sen=0");
        idle("R8 irq single");
        step(1, 0, 1, 1, 0, 0, 0, 0, "R8 no irq while held");
        step(1, 0, 1, 0, 0, 0, 1, 1, "R6 host release");
        step(1, 0, 1, 1, 0, 1, 0, 0, "R4 tx stretch sen=1");
        step(1, 0, 1, 0, 0, 1, 1, 1, "R6 release");
        // R3
        step(1, 0, 1, 1, 1, 0, 0, 0, "R3 full buffer");
        step(1, 0, 1, 1, 1, 1, 0, 0, "R3 full buffer sen=1");
        // R5
        step(1, 0, 0, 1, 0, 0, 0, 0, "R5 rx no stretch");
        step(1, 0, 0, 1, 0, 1, 0, 0, "R5 rx stretch");
        step(1, 0, 0, 0, 0, 1, 1, 1, "R6 rx release");
        // R7
        step(1, 0, 0, 0, 0, 0, 1, 0, "R7 clear ignored");
        idle("R7 still free");
        step(1, 0, 0, 0, 0, 1, 1, 0, "R7 host clear");
        idle("R8 no irq sw hold");
        step(1, 0, 0, 0, 0, 0, 1, 1, "R6 release sw hold");
        // R7 ignored while held: rel stays 0
        step(1, 0, 1, 1, 0, 0, 0, 0, "R2 hold again");
        step(1, 0, 1, 0, 0, 0, 1, 0, "R7 ignored while held");
        // R9
        step(1, 1, 1, 0, 0, 0, 0, 0, "R9 stop frees");
        step(1, 0, 1, 1, 0, 0, 0, 0, "R2 hold");
        step(0, 0, 1, 1, 0, 1, 1, 0, "R9 disable frees");
        step(1, 1, 1, 1, 0, 1, 0, 0, "R9 stop beats trigger");
        // R10
        step(1, 0, 1, 1, 0, 1, 1, 1, "R10 trigger beats write");
        step(1, 0, 1, 0, 0, 1, 1, 1, "R6 release");
        step(1, 0, 0, 1, 0, 1, 1, 1, "R10 rx trigger beats write");
        step(1, 0, 0, 0, 0, 1, 1, 1, "R6 release");

        // constrained random: R11 checked on every compare
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 32) != 0, ($urandom % 40) == 0, $urandom % 2,
                 ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
                 ($urandom % 6) == 0, $urandom % 2, "R11 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule